// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block carries out one serial flash command on a single-lane SPI bus. A pulse on `start` latches a command bundle. The bundle gives the instruction length and code, the address length and value, an optional enhanced-mode opcode, a count of dummy cycles, a byte count and a transfer direction. The block then clocks out the enabled phases in this fixed order: instruction, address, enhanced-mode opcode, dummy cycles, data. It skips any phase that the bundle disables, and skipping costs no bus time.

Write bytes arrive on a valid/ready stream. Read bytes leave on a second valid/ready stream. The bus clock pauses, held low, whenever either stream is not ready to continue. The block checks the bundle before it starts. It refuses reserved length codes and out-of-range dummy counts. It also refuses an instruction-less command until an enhanced-mode command has completed. Every accepted command ends with a `done` pulse.

Top module: `sfc_seq`

## Requirements
- R1: `cs_n` goes low in the cycle after an accepted `start`, before the first rising edge of `sck`. It stays low through every phase. `busy` is high from that cycle until the command ends.
- R2: The bus runs in SPI mode 0 and sends MSB first. `sck` idles low, and each bit lasts `CLK_DIV` system clocks with `sck` high for `CLK_DIV/2` of them. `mosi` changes only while `sck` is low. `miso` is sampled at the rising edge of `sck`.
- R3: Instruction length code 0 sends no instruction and code 1 sends `ins_code` once. Code 2 sends `ins_code` twice.
- R4: Address length code 0 sends no address. Codes 1 to 4 send the low 1 to 4 bytes of `adr`, most significant of those bytes first.
- R5: When `mode_en` is set, `mode_code` is sent as one byte right after the address phase and before any dummy cycles.
- R6: After the address and opcode, `dummy_cnt` cycles (0 to 32) are clocked with `mosi` high. They are skipped entirely when the address length is 0.
- R7: `data_cnt` = 0 gives no data phase. Otherwise exactly `data_cnt` bytes are transferred, and no extra `sck` pulse is produced.
- R8: In a write (`write_en`=1), `wr_ready` is high only between data bytes. While it waits for `wr_valid`, `sck` stays low. The accepted byte is sent MSB first.
- R9: In a read, each received byte appears on `rd_data` with `rd_valid` high. It stays unchanged until `rd_ready` is seen, and `rd_valid` drops in the next cycle. `sck` stays low while a byte waits, so the next byte is not clocked in before the previous one is taken.
- R10: A `start` with instruction length 3, address length 5 to 7, or a nonzero address length together with `dummy_cnt` > 32 is refused. `cfg_err` pulses for one cycle after `start`, and `busy`, `cs_n` and `sck` stay idle.
- R11: An instruction-less command is refused with `cfg_err` unless the most recently completed command had `mode_en` set. The block leaves reset with this permission cleared.
- R12: After the last bit, `cs_n` rises while `busy` is still high and stays high for at least `CLK_DIV` cycles. `busy` then falls, and `done` is high for exactly that one cycle.
- R13: A `start` while `busy` is high is ignored. It raises no `cfg_err`, and the running command continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latch the command bundle and begin |
| ins_len | input | 2 | Instruction length code (0 none, 1 one byte, 2 repeated byte, 3 reserved) |
| ins_code | input | 8 | Instruction byte |
| adr_len | input | 3 | Address byte count (0 to 4, others reserved) |
| adr | input | 32 | Address value |
| mode_en | input | 1 | Send the enhanced-mode opcode |
| mode_code | input | 8 | Enhanced-mode opcode byte |
| dummy_cnt | input | 6 | Dummy cycles after the address (0 to 32) |
| data_cnt | input | 32 | Data byte count, 0 for none |
| write_en | input | 1 | 1 write data, 0 read data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| cfg_err | output | 1 | One-cycle pulse for a refused command |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| wr_data | input | 8 | Write byte |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte taken |

## Verification
The hardest behaviour to reach from the ports is the permission rule for instruction-less commands. It depends on the history of earlier commands, not on the bundle being issued. The stimulus therefore runs a fixed sequence. It first issues an instruction-less command straight after reset, which must be refused. It then completes an enhanced-mode read, after which the same kind of command must be accepted. Finally it completes a plain command, after which the instruction-less command must be refused again. Stalls are provoked by a write feeder that waits a few cycles before every byte and a read consumer that holds each byte for several cycles. A second `start` with a reserved code is injected in the middle of a transfer.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    localparam int DCNT_W    = 32;
    localparam int MAX_DUMMY = 32;

    typedef enum logic [3:0] {
        PH_IDLE, PH_INS, PH_ADR, PH_MODE, PH_DUM,
        PH_DLOAD, PH_DATA, PH_END, PH_GAP
    } phase_e;

    typedef struct packed {
        logic [1:0]        ins_len;
        logic [7:0]        ins_code;
        logic [2:0]        adr_len;
        logic [31:0]       adr;
        logic              mode_en;
        logic [7:0]        mode_code;
        logic [5:0]        dummy;
        logic [DCNT_W-1:0] dcnt;
        logic              write;
    } cmd_t;

    typedef struct packed {
        logic [31:0] sh;
        logic [5:0]  bits;
    } load_t;

    localparam cmd_t CMD_RESET = '{ins_len: 2'd1, ins_code: 8'h00, adr_len: 3'd3,
                                   adr: 32'h0, mode_en: 1'b0, mode_code: 8'h00,
                                   dummy: 6'd0, dcnt: '0, write: 1'b0};

    // First enabled phase strictly after 'cur'; phases run in fixed order.
    function automatic phase_e next_phase(phase_e cur, cmd_t c);
        if (int'(cur) < int'(PH_INS) && c.ins_len != 2'd0) return PH_INS;
        if (int'(cur) < int'(PH_ADR) && c.adr_len != 3'd0) return PH_ADR;
        if (int'(cur) < int'(PH_MODE) && c.mode_en) return PH_MODE;
        if (int'(cur) < int'(PH_DUM) && c.adr_len != 3'd0 && c.dummy != 6'd0) return PH_DUM;
        if (int'(cur) < int'(PH_DLOAD) && c.dcnt != '0) return PH_DLOAD;
        return PH_END;
    endfunction

    // Shift register image and bit count on entry to a serial phase.
    function automatic load_t load_phase(phase_e ph, cmd_t c);
        load_t l;
        l.sh   = '0;
        l.bits = '0;
        case (ph)
            PH_INS: begin
                l.sh   = {c.ins_code, c.ins_code, 16'h0000};
                l.bits = (c.ins_len == 2'd2) ? 6'd16 : 6'd8;
            end
            PH_ADR: begin
                l.sh   = c.adr << (8 * (4 - int'(c.adr_len)));
                l.bits = {c.adr_len, 3'b000};
            end
            PH_MODE: begin
                l.sh   = {c.mode_code, 24'h000000};
                l.bits = 6'd8;
            end
            PH_DUM: begin
                l.sh   = '1;
                l.bits = c.dummy;
            end
            default: ;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/sfc_cfgchk.sv
module sfc_cfgchk
    import sfc_pkg::*;
(
    input  logic [1:0] ins_len,
    input  logic [2:0] adr_len,
    input  logic [5:0] dummy,
    input  logic       resume_ok,
    output logic       bad
);
    logic ins_rsvd, adr_rsvd, dum_rsvd, no_ins_blocked;

    always_comb begin
        ins_rsvd       = (ins_len == 2'd3);
        adr_rsvd       = (adr_len > 3'd4);
        dum_rsvd       = (adr_len != 3'd0) && (int'(dummy) > MAX_DUMMY);
        no_ins_blocked = (ins_len == 2'd0) && !resume_ok;
        bad            = ins_rsvd || adr_rsvd || dum_rsvd || no_ins_blocked;
    end
endmodule

// File: rtl/sfc_sckgen.sv
module sfc_sckgen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sck,
    output logic smp,
    output logic bit_end
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (cnt == CW'(CLK_DIV - 1)) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end

    assign sck     = run && (cnt >= CW'(HALF));
    assign smp     = run && (cnt == CW'(HALF - 1));
    assign bit_end = run && (cnt == CW'(CLK_DIV - 1));

    AST_SMP_BEFORE_RISE: assert property (@(posedge clk) disable iff (rst) smp |=> sck); // R2
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) !run |=> (cnt == '0)); // R2
endmodule

// File: rtl/sfc_seq.sv
module sfc_seq
    import sfc_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [1:0]  ins_len,
    input  logic [7:0]  ins_code,
    input  logic [2:0]  adr_len,
    input  logic [31:0] adr,
    input  logic        mode_en,
    input  logic [7:0]  mode_code,
    input  logic [5:0]  dummy_cnt,
    input  logic [31:0] data_cnt,
    input  logic        write_en,
    output logic        busy,
    output logic        done,
    output logic        cfg_err,
    output logic        sck,
    output logic        cs_n,
    output logic        mosi,
    input  logic        miso,
    input  logic [7:0]  wr_data,
    input  logic        wr_valid,
    output logic        wr_ready,
    output logic [7:0]  rd_data,
    output logic        rd_valid,
    input  logic        rd_ready
);
    localparam int GW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

    phase_e        state;
    cmd_t          cfg, cmd_in;
    logic [31:0]   sh;
    logic [5:0]    bits;
    logic [7:0]    rx;
    logic [GW-1:0] gcnt;
    logic          resume_ok, cfg_bad, run, smp, bit_end;
    phase_e        nx_start, nx_cur;
    load_t         ld_start, ld_cur;

    assign cmd_in = '{ins_len: ins_len, ins_code: ins_code, adr_len: adr_len, adr: adr,
                      mode_en: mode_en, mode_code: mode_code, dummy: dummy_cnt,
                      dcnt: data_cnt, write: write_en};

    sfc_cfgchk i_chk (
        .ins_len  (ins_len),
        .adr_len  (adr_len),
        .dummy    (dummy_cnt),
        .resume_ok(resume_ok),
        .bad      (cfg_bad)
    );

    always_comb begin
        run = (state == PH_INS) || (state == PH_ADR) || (state == PH_MODE) ||
              (state == PH_DUM) || (state == PH_DATA);
        nx_start = next_phase(PH_IDLE, cmd_in);
        nx_cur   = next_phase(state, cfg);
        ld_start = load_phase(nx_start, cmd_in);
        ld_cur   = load_phase(nx_cur, cfg);
    end

    sfc_sckgen #(.CLK_DIV(CLK_DIV)) i_sck (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .sck    (sck),
        .smp    (smp),
        .bit_end(bit_end)
    );

    assign mosi     = sh[31];
    assign cs_n     = (state == PH_IDLE) || (state == PH_GAP);
    assign busy     = (state != PH_IDLE);
    assign wr_ready = (state == PH_DLOAD) && cfg.write;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PH_IDLE;
            cfg       <= CMD_RESET;
            sh        <= '0;
            bits      <= '0;
            rx        <= '0;
            gcnt      <= '0;
            resume_ok <= 1'b0;
            done      <= 1'b0;
            cfg_err   <= 1'b0;
            rd_data   <= '0;
            rd_valid  <= 1'b0;
        end else begin
            done    <= 1'b0;
            cfg_err <= 1'b0;
            if (rd_valid && rd_ready) rd_valid <= 1'b0;
            if (smp) rx <= {rx[6:0], miso};
            case (state)
                PH_IDLE: if (start) begin
                    if (cfg_bad) begin
                        cfg_err <= 1'b1;
                    end else begin
                        cfg   <= cmd_in;
                        state <= nx_start;
                        sh    <= ld_start.sh;
                        bits  <= ld_start.bits;
                    end
                end
                PH_INS, PH_ADR, PH_MODE, PH_DUM: if (bit_end) begin
                    if (bits == 6'd1) begin
                        state <= nx_cur;
                        sh    <= ld_cur.sh;
                        bits  <= ld_cur.bits;
                    end else begin
                        sh   <= {sh[30:0], 1'b1};
                        bits <= bits - 1'b1;
                    end
                end
                PH_DLOAD: begin
                    if (cfg.write && wr_valid) begin
                        sh    <= {wr_data, 24'h000000};
                        bits  <= 6'd8;
                        state <= PH_DATA;
                    end else if (!cfg.write && !rd_valid) begin
                        sh    <= '0;
                        bits  <= 6'd8;
                        state <= PH_DATA;
                    end
                end
                PH_DATA: if (bit_end) begin
                    if (bits == 6'd1) begin
                        if (!cfg.write) begin
                            rd_data  <= rx;
                            rd_valid <= 1'b1;
                        end
                        cfg.dcnt <= cfg.dcnt - 1'b1;
                        state    <= (cfg.dcnt == 32'd1) ? PH_END : PH_DLOAD;
                    end else begin
                        sh   <= {sh[30:0], 1'b1};
                        bits <= bits - 1'b1;
                    end
                end
                PH_END: if (cfg.write || !rd_valid) begin
                    state <= PH_GAP;
                    gcnt  <= '0;
                end
                PH_GAP: begin
                    if (gcnt == GW'(CLK_DIV - 1)) begin
                        state     <= PH_IDLE;
                        done      <= 1'b1;
                        resume_ok <= cfg.mode_en;
                    end else begin
                        gcnt <= gcnt + 1'b1;
                    end
                end
                default: state <= PH_IDLE;
            endcase
        end
    end

    AST_SCK_UNDER_CS: assert property (@(posedge clk) disable iff (rst) sck |-> !cs_n); // R1
    AST_DUMMY_HIGH: assert property (@(posedge clk) disable iff (rst) (state == PH_DUM) |-> mosi); // R6
    AST_WR_STALL: assert property (@(posedge clk) disable iff (rst) (wr_ready && !wr_valid) |=> !sck); // R8
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R9
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst) cfg_err |-> (!busy && cs_n)); // R10
    AST_CS_RISE_BUSY: assert property (@(posedge clk) disable iff (rst) $rose(cs_n) |-> busy); // R12
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R12
endmodule

// File: tb/test_sfc_seq.sv
module test_sfc_seq;
    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        start = 1'b0;
    logic [1:0]  ins_len = 2'd1;
    logic [7:0]  ins_code = 8'h00;
    logic [2:0]  adr_len = 3'd3;
    logic [31:0] adr = 32'h0;
    logic        mode_en = 1'b0;
    logic [7:0]  mode_code = 8'h00;
    logic [5:0]  dummy_cnt = 6'd0;
    logic [31:0] data_cnt = 32'd0;
    logic        write_en = 1'b0;
    logic        miso = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        wr_valid = 1'b0;
    logic        rd_ready = 1'b0;
    logic        busy, done, cfg_err, sck, cs_n, mosi, wr_ready, rd_valid;
    logic [7:0]  rd_data;

    sfc_seq #(.CLK_DIV(DIV)) i_sfc_seq (
        .clk(clk), .rst(rst), .start(start), .ins_len(ins_len), .ins_code(ins_code),
        .adr_len(adr_len), .adr(adr), .mode_en(mode_en), .mode_code(mode_code),
        .dummy_cnt(dummy_cnt), .data_cnt(data_cnt), .write_en(write_en),
        .busy(busy), .done(done), .cfg_err(cfg_err), .sck(sck), .cs_n(cs_n),
        .mosi(mosi), .miso(miso), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic       exp_q[$];
    string      tag_q[$];
    logic       miso_q[$];
    logic [7:0] wr_q[$];
    logic [7:0] rd_exp_q[$];
    logic [7:0] dbytes[$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_bits(input logic [31:0] v, input int n, input string tag);
        for (int i = n - 1; i >= 0; i--) begin
            exp_q.push_back(v[i]);
            tag_q.push_back(tag);
        end
    endtask

    // Scoreboard driver: expected MOSI stream, MISO image and data queues
    task automatic expect_cmd(input logic [1:0] il, input logic [7:0] ic, input logic [2:0] al,
                              input logic [31:0] ad, input logic me, input logic [7:0] mc,
                              input logic [5:0] dm, input logic wr);
        int p = 0;
        if (il == 2'd1) begin push_bits(32'(ic), 8, "R3 instruction"); p += 8; end
        if (il == 2'd2) begin push_bits(32'(ic), 8, "R3 instruction first"); push_bits(32'(ic), 8, "R3 instruction repeat"); p += 16; end
        for (int k = int'(al) - 1; k >= 0; k--) begin push_bits(32'(ad[8*k +: 8]), 8, "R4 address byte"); p += 8; end
        if (me) begin push_bits(32'(mc), 8, "R5 opcode after address"); p += 8; end
        if (al != 3'd0) for (int k = 0; k < int'(dm); k++) begin push_bits(32'd1, 1, "R6 dummy high"); p++; end
        for (int k = 0; k < p; k++) miso_q.push_back(1'b0);
        foreach (dbytes[j]) begin
            if (wr) begin
                wr_q.push_back(dbytes[j]);
                push_bits(32'(dbytes[j]), 8, "R8 write data");
            end else begin
                rd_exp_q.push_back(dbytes[j]);
                for (int i = 7; i >= 0; i--) begin
                    miso_q.push_back(dbytes[j][i]);
                    exp_q.push_back(1'bx);
                    tag_q.push_back("R7 read bit");
                end
            end
        end
    endtask

    task automatic issue(input logic [1:0] il, input logic [7:0] ic, input logic [2:0] al,
                         input logic [31:0] ad, input logic me, input logic [7:0] mc,
                         input logic [5:0] dm, input logic wr, input bit ok, input string tg);
        int n = 0;
        @(negedge clk);
        ins_len = il; ins_code = ic; adr_len = al; adr = ad; mode_en = me;
        mode_code = mc; dummy_cnt = dm; data_cnt = 32'(dbytes.size()); write_en = wr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!ok) begin
            chk(cfg_err && !busy && cs_n && !sck, {tg, " R10 refused"}, {cfg_err, busy, cs_n}, 3'b101);
            @(negedge clk);
            chk(!cfg_err && !busy, {tg, " R10 cfg_err one cycle"}, {cfg_err, busy}, 2'b00);
        end else begin
            chk(busy && !cs_n && !cfg_err, {tg, " R1 busy and cs_n low"}, {busy, cs_n, cfg_err}, 3'b100);
            while (!done && n < 20000) begin @(negedge clk); n++; end
            chk(done, {tg, " R12 done reached"}, done, 1);
            chk(exp_q.size() == 0, {tg, " R7 all bits sent"}, exp_q.size(), 0);
            chk(rd_exp_q.size() == 0 && wr_q.size() == 0, {tg, " R7 all bytes moved"},
                rd_exp_q.size() + wr_q.size(), 0);
        end
        exp_q.delete(); tag_q.delete(); miso_q.delete(); dbytes.delete();
    endtask

    // Bus monitor and flash model
    initial begin
        logic sck_p = 0, cs_p = 1, busy_p = 0, done_p = 0, at_rise = 0;
        int hcnt = 0, gap = 0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (sck && !sck_p) begin
                    logic b; string t;
                    if (exp_q.size() == 0) chk(0, "R7 extra sck pulse", 1, 0);
                    else begin
                        b = exp_q.pop_front(); t = tag_q.pop_front();
                        if (b !== 1'bx) chk(mosi == b, t, mosi, b);
                    end
                    chk(!cs_n, "R1 cs_n low at sck rise", cs_n, 0);
                    hcnt = 1; at_rise = mosi;
                end else if (sck) begin
                    hcnt++;
                    chk(mosi == at_rise, "R2 mosi stable while sck high", mosi, at_rise);
                end
                if (!sck && sck_p) chk(hcnt == HALF, "R2 sck high time", hcnt, HALF);
                if ((cs_p && !cs_n) || (!sck && sck_p))
                    miso = (miso_q.size() > 0) ? miso_q.pop_front() : 1'b0;
                if (wr_ready && !wr_valid) chk(!sck, "R8 sck low while write stalled", sck, 0);
                if (rd_valid) chk(!sck, "R9 sck low while read byte pending", sck, 0);
                if (cs_n && busy) gap++;
                if (busy_p && !busy) begin
                    chk(gap >= DIV, "R12 cs_n high time before end", gap, DIV);
                    chk(done, "R12 done when busy falls", done, 1);
                    gap = 0;
                end
                if (done_p) chk(!done, "R12 done single cycle", done, 0);
                sck_p = sck; cs_p = cs_n; busy_p = busy; done_p = done;
            end
        end
    end

    // Write stream source with a stall before every byte
    initial begin
        bit taken = 0;
        int wait_n = 3;
        forever begin
            @(negedge clk);
            if (taken) begin
                wr_valid = 1'b0; taken = 0; wait_n = 3;
            end else if (wr_valid && wr_ready) begin
                taken = 1;
            end else if (!wr_valid && wr_q.size() > 0) begin
                if (wait_n > 0) wait_n--;
                else begin wr_data = wr_q.pop_front(); wr_valid = 1'b1; end
            end
        end
    end

    // Read stream sink holding each byte for a few cycles
    initial begin
        int hold = 0;
        logic [7:0] first = 0;
        forever begin
            @(negedge clk);
            if (rd_ready) begin
                rd_ready = 1'b0;
                chk(!rd_valid, "R9 rd_valid clears after ready", rd_valid, 0);
            end else if (rd_valid) begin
                if (hold == 0) first = rd_data;
                else chk(rd_data == first, "R9 rd_data held", rd_data, first);
                hold++;
                if (hold == 4) begin
                    logic [7:0] e;
                    e = (rd_exp_q.size() > 0) ? rd_exp_q.pop_front() : 8'hxx;
                    chk(rd_data == e, "R9 read byte value", rd_data, e);
                    rd_ready = 1'b1; hold = 0;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n && !sck && !busy && !done && !cfg_err && !wr_ready && !rd_valid,
            "R1 reset state idle", {cs_n, sck, busy, done, cfg_err, wr_ready, rd_valid}, 7'b1000000);

        // R11: no instruction right after reset is refused
        issue(2'd0, 8'h00, 3'd1, 32'h0, 1'b0, 8'h00, 6'd0, 1'b0, 0, "R11 no-ins after reset");

        // R3 R4 R7 R8: one-byte instruction, 3-byte address, stalled write
        dbytes = '{8'hA5, 8'h3C};
        expect_cmd(2'd1, 8'h02, 3'd3, 32'hFF123456, 1'b0, 8'h00, 6'd0, 1'b1);
        issue(2'd1, 8'h02, 3'd3, 32'hFF123456, 1'b0, 8'h00, 6'd0, 1'b1, 1, "write cmd");

        // R3 R4 R5 R6 R9: repeated instruction, 4-byte address, opcode, dummy, read
        dbytes = '{8'h81, 8'h7E, 8'hC3};
        expect_cmd(2'd2, 8'hEB, 3'd4, 32'hDEADBEEF, 1'b1, 8'hA0, 6'd5, 1'b0);
        issue(2'd2, 8'hEB, 3'd4, 32'hDEADBEEF, 1'b1, 8'hA0, 6'd5, 1'b0, 1, "enhanced read");

        // R11: no instruction now accepted, 1-byte address, 2 dummy cycles
        dbytes = '{8'h96};
        expect_cmd(2'd0, 8'h00, 3'd1, 32'h00000055, 1'b1, 8'h5A, 6'd2, 1'b0);
        issue(2'd0, 8'h00, 3'd1, 32'h00000055, 1'b1, 8'h5A, 6'd2, 1'b0, 1, "R11 no-ins accepted");

        // R6 R7: no address so dummy skipped, no data phase
        expect_cmd(2'd1, 8'h06, 3'd0, 32'h0, 1'b0, 8'h00, 6'd7, 1'b0);
        issue(2'd1, 8'h06, 3'd0, 32'h0, 1'b0, 8'h00, 6'd7, 1'b0, 1, "R6 dummy skipped");

        // R11: plain command completed, permission withdrawn
        issue(2'd0, 8'h00, 3'd2, 32'h0, 1'b0, 8'h00, 6'd0, 1'b0, 0, "R11 no-ins after plain");

        // R10: reserved encodings
        issue(2'd3, 8'h11, 3'd3, 32'h0, 1'b0, 8'h00, 6'd0, 1'b0, 0, "R10 ins code 3");
        issue(2'd1, 8'h11, 3'd5, 32'h0, 1'b0, 8'h00, 6'd0, 1'b0, 0, "R10 adr code 5");
        issue(2'd1, 8'h11, 3'd2, 32'h0, 1'b0, 8'h00, 6'd40, 1'b0, 0, "R10 dummy 40");

        // R13: start with a bad bundle while busy is ignored; 32 dummy cycles
        dbytes = '{8'h5B};
        expect_cmd(2'd1, 8'h3B, 3'd2, 32'h0000C0DE, 1'b0, 8'h00, 6'd32, 1'b1);
        fork
            issue(2'd1, 8'h3B, 3'd2, 32'h0000C0DE, 1'b0, 8'h00, 6'd32, 1'b1, 1, "R13 busy cmd");
            begin
                repeat (30) @(negedge clk);
                ins_len = 2'd3; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                chk(!cfg_err && busy, "R13 start ignored while busy", {cfg_err, busy}, 2'b01);
            end
        join

        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule